// File: doc/BRIEF.md
# Dual-Role Open-Drain Port with Multiplexed Address/Data Drive

This block is an array of bidirectional port cells, eight by default. Each cell serves in one of two roles. As a general-purpose I/O pin, a per-bit output latch sets the drive. A latch bit of 0 turns on the low-side transistor. A latch bit of 1 releases the pin, which then needs an external pull-up to read high. As one lane of a time-shared low address/data bus during external memory cycles, the cell drives push-pull from the internal address/data value. A set bit turns on the high side, and a clear bit turns on the low side.

The role select line is registered. A change on it takes effect at the drivers one clock later, and the latch is untouched while the bus role is active. Two read paths are offered: the sampled pin level, and the stored latch value. A reading of the pin as an input is only meaningful once a 1 has been written to that bit. A small pin resolver module, used by the bench, turns the drive enables and external conditions into a pin level.

Top module: `muxIoPort`

## Requirements
- R1: While reset is asserted and after its release, the latch holds all ones and both drive enables are 0 for every bit, so that no bit is driven.
- R2: When wrEn is 1 at a rising clock edge, wrData is stored in the latch, and rdLatch shows it from that edge on. With wrEn at 0, the latch keeps its value.
- R3: In I/O role, pullUp is 0 on every bit and pullDown is the bitwise inverse of the latch.
- R4: In bus role, for each bit pullUp equals the adBus bit and pullDown equals its inverse.
- R5: The role is taken from busSel (1 = bus, 0 = I/O) sampled at each rising edge. The drive enables follow the new role from that edge on.
- R6: pullUp and pullDown are never both 1 on the same bit, in either role.
- R7: rdPin returns pinIn. With a latch bit at 0, the resolved pin and so rdPin read 0 even when an external pull-up is present. With a latch bit at 1, they follow the external level.
- R8: Leaving bus role does not change the latch, and the I/O drives return to the inverse of the latched value on the cycle after the role change.
- R9: A latch write made during bus role is stored but does not affect the drives until the port returns to the I/O role.
- R10: The resolver gives level 0 and known 1 when a bit is pulled low. It gives level 1 and known 1 when the bit is driven high or has an external pull-up. It gives known 0 when the bit floats with no pull-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Latch write strobe |
| wrData | input | WIDTH | Internal write data for the latch |
| busSel | input | 1 | Role select, 1 = external memory address/data bus |
| adBus | input | WIDTH | Internal address/data value driven in bus role |
| pinIn | input | WIDTH | Sampled pin levels |
| pullDown | output | WIDTH | Low-side driver enable per bit |
| pullUp | output | WIDTH | High-side driver enable per bit |
| rdPin | output | WIDTH | Read-pin value |
| rdLatch | output | WIDTH | Read-latch value |

## Verification
Several properties are checked on every cycle. No bit ever has both drivers enabled. The high side stays off in the I/O role, and the two enables are complementary in the bus role. The latch loads only on a write strobe, and the registered role tracks its select line. Other behaviours need whole scenarios in the bench, built with the pin resolver. One is that a bit whose latch holds 0 masks the external level on the read-pin path. Another is that a floating pin with no pull-up is reported as unknown. A third is that a write made during bus role stays hidden until the port returns to the I/O role.

// File: rtl/muxIoPkg.sv
package muxIoPkg;
  typedef struct packed {
    logic latchWr;
    logic busMode;
  } portStrobes_t;
endpackage

// File: rtl/muxIoCtrl.sv
module muxIoCtrl
  import muxIoPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic         busSel,
  output portStrobes_t strb
);
  logic busModeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busModeQ <= 1'b0;
    else       busModeQ <= busSel;
  end

  always_comb begin
    strb.latchWr = wrEn;
    strb.busMode = busModeQ;
  end

  // R5
  mode_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (strb.busMode == $past(busSel)));
endmodule

// File: rtl/muxIoDatapath.sv
module muxIoDatapath
  import muxIoPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  portStrobes_t     strb,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] adBus,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pullDown,
  output logic [WIDTH-1:0] pullUp,
  output logic [WIDTH-1:0] rdPin,
  output logic [WIDTH-1:0] rdLatch
);
  localparam logic [WIDTH-1:0] LatchInit = '1;

  logic [WIDTH-1:0] latchQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             latchQ <= LatchInit;
    else if (strb.latchWr) latchQ <= wrData;
  end

  for (genvar b = 0; b < WIDTH; b++) begin : gCell
    always_comb begin
      if (strb.busMode) begin
        pullUp[b]   = adBus[b];
        pullDown[b] = ~adBus[b];
      end else begin
        pullUp[b]   = 1'b0;
        pullDown[b] = ~latchQ[b];
      end
    end
  end

  assign rdPin   = pinIn;
  assign rdLatch = latchQ;

  // R6
  no_contention_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pullDown & pullUp) == '0);
  // R3
  gpio_high_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.busMode |-> (pullUp == '0));
  // R4
  bus_complement_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.busMode |-> ((pullUp ^ pullDown) == '1));
  // R2
  latch_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchWr |=> (rdLatch == $past(wrData)));
  // R8
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchWr |=> $stable(rdLatch));
endmodule

// File: rtl/pinResolver.sv
module pinResolver #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] pullDown,
  input  logic [WIDTH-1:0] pullUp,
  input  logic [WIDTH-1:0] extPullUp,
  input  logic [WIDTH-1:0] extLow,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] known
);
  for (genvar b = 0; b < WIDTH; b++) begin : gPin
    always_comb begin
      if (pullDown[b] || extLow[b]) begin
        level[b] = 1'b0;
        known[b] = 1'b1;
      end else if (pullUp[b] || extPullUp[b]) begin
        level[b] = 1'b1;
        known[b] = 1'b1;
      end else begin
        level[b] = 1'b0;
        known[b] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/muxIoPort.sv
module muxIoPort
  import muxIoPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             busSel,
  input  logic [WIDTH-1:0] adBus,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pullDown,
  output logic [WIDTH-1:0] pullUp,
  output logic [WIDTH-1:0] rdPin,
  output logic [WIDTH-1:0] rdLatch
);
  portStrobes_t strb;

  muxIoCtrl uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .busSel(busSel), .strb(strb)
  );

  muxIoDatapath #(.WIDTH(WIDTH)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .adBus(adBus),
    .pinIn(pinIn), .pullDown(pullDown), .pullUp(pullUp),
    .rdPin(rdPin), .rdLatch(rdLatch)
  );
endmodule

// File: tb/muxIoPort_test.sv
module muxIoPort_test;
  localparam int W = 8;
  localparam int NV = 8;
  // {wrEn, wrData, busSel, adBus, expPullDown, expPullUp}
  localparam logic [33:0] VEC [NV] = '{
    {1'b1, 8'h5A, 1'b0, 8'h00, 8'hA5, 8'h00},
    {1'b0, 8'h00, 1'b0, 8'hFF, 8'hA5, 8'h00},
    {1'b0, 8'h00, 1'b1, 8'h3C, 8'hC3, 8'h3C},
    {1'b1, 8'h0F, 1'b1, 8'h81, 8'h7E, 8'h81},
    {1'b0, 8'h00, 1'b0, 8'h81, 8'hF0, 8'h00},
    {1'b1, 8'hFF, 1'b0, 8'h00, 8'h00, 8'h00},
    {1'b1, 8'h00, 1'b0, 8'h00, 8'hFF, 8'h00},
    {1'b0, 8'h00, 1'b1, 8'hFF, 8'h00, 8'hFF}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic busSel = 1'b0;
  logic [W-1:0] wrData = '0, adBus = '0;
  logic [W-1:0] extPullUp = '0, extLow = '0;
  logic [W-1:0] pinLevel, pinKnown, pullDown, pullUp, rdPin, rdLatch;
  int nChecks = 0, nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  muxIoPort #(.WIDTH(W)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .busSel(busSel),
    .adBus(adBus), .pinIn(pinLevel), .pullDown(pullDown), .pullUp(pullUp),
    .rdPin(rdPin), .rdLatch(rdLatch)
  );

  pinResolver #(.WIDTH(W)) uPins (
    .pullDown(pullDown), .pullUp(pullUp), .extPullUp(extPullUp),
    .extLow(extLow), .level(pinLevel), .known(pinKnown)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [W-1:0] wd, input logic bs, input logic [W-1:0] ad);
    wrEn = we; wrData = wd; busSel = bs; adBus = ad;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 latch in reset", rdLatch, 8'hFF);
    check("R1 pullUp in reset", pullUp, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 pullDown after reset", pullDown, 8'h00);
    check("R1 latch after reset", rdLatch, 8'hFF);

    // Table walk: R2 R3 R4 R5 R6 R8 R9
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][33], VEC[i][32:25], VEC[i][24], VEC[i][23:16]);
      check($sformatf("R3/R4/R5 pullDown vec %0d", i), pullDown, VEC[i][15:8]);
      check($sformatf("R3/R4/R5 pullUp vec %0d", i), pullUp, VEC[i][7:0]);
      check($sformatf("R6 contention vec %0d", i), pullDown & pullUp, 8'h00);
    end

    // R9: write during bus role hidden, R8: revealed on return
    step(1'b1, 8'hC3, 1'b1, 8'hAA);
    check("R9 bus drive unchanged by write", pullDown, 8'h55);
    check("R2 latch written in bus role", rdLatch, 8'hC3);
    step(1'b0, 8'h00, 1'b0, 8'hAA);
    check("R8 latch kept after bus exit", rdLatch, 8'hC3);
    check("R8 gpio drive restored", pullDown, 8'h3C);
    // R5: busSel change not seen before the edge
    busSel = 1'b1; adBus = 8'hFF;
    #1;
    check("R5 role not yet switched", pullUp, 8'h00);
    step(1'b0, 8'h00, 1'b0, 8'h00);

    // R7: latch all ones, pins follow external levels
    step(1'b1, 8'hFF, 1'b0, 8'h00);
    extPullUp = 8'hFF; extLow = 8'h0F;
    #1;
    check("R7 rdPin follows external", rdPin, 8'hF0);
    check("R10 known when pulled", pinKnown, 8'hFF);
    // R7: latch zero masks external pull-up
    step(1'b1, 8'h00, 1'b0, 8'h00);
    extLow = 8'h00;
    #1;
    check("R7 rdPin masked by latch 0", rdPin, 8'h00);
    check("R2 rdLatch vs rdPin", rdLatch, 8'h00);
    // R10: floating without pull-up
    step(1'b1, 8'hF0, 1'b0, 8'h00);
    extPullUp = 8'h30;
    #1;
    check("R10 known mask", pinKnown, 8'h3F);
    check("R10 level", pinLevel, 8'h30);
    // R10: driven high in bus role
    extPullUp = 8'h00;
    step(1'b0, 8'h00, 1'b1, 8'h99);
    check("R10 bus driven level", pinLevel, 8'h99);
    check("R10 bus driven known", pinKnown, 8'hFF);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule